// File: doc/BRIEF.md
# Serial Flash Identification Probe

This block runs the standard read-identification exchange with a serial NOR flash and decides whether the part that answers is the one the system expects. A start pulse makes it lower chip select and send the identify opcode through a byte-wide SPI shifter. The shifter is modelled as a request/acknowledge port that moves one byte per handshake. The block then clocks in either three or four response bytes, as a length input selects, and raises chip select again.

The response is split into a manufacturer code and a device code. A leading continuation byte (0x7F) widens the manufacturer code to two bytes and shifts the device code along by one byte. The first byte, and the second byte when the continuation prefix is present, should carry odd parity. A violation only raises a warning. The parsed codes are compared with an expected pair. Either expected field can hold a wildcard value that relaxes the comparison. The block presents the codes, a match flag and the warning together with a one-cycle done pulse, and holds them until the next transaction.

Top module: `flash_id_probe`

## Requirements
- R1: A start pulse while idle begins a transaction whose first byte on `spi_tx_o` is 0x9F. A start pulse while a transaction is in progress is ignored and does not cause a second transaction.
- R2: With `four_byte_i` = 0 the transaction moves exactly 4 bytes (opcode plus 3 response bytes). With `four_byte_i` = 1 it moves exactly 5 bytes. Response bytes are sent as 0x00 on `spi_tx_o`, and the byte returned with the opcode handshake is discarded.
- R3: `spi_cs_n_o` is low continuously from the opcode request through the acknowledge of the last response byte, and it is high again by the time `done_o` is asserted.
- R4: When response byte 0 is not 0x7F, `mfr_id_o` = {0x00, byte0} and `dev_id_o` = {byte1, byte2}.
- R5: When response byte 0 is 0x7F, `mfr_id_o` = {byte0, byte1}. `dev_id_o` = {byte2, byte3} in four-byte mode and {0x00, byte2} in three-byte mode.
- R6: In four-byte mode with byte 0 not 0x7F, response byte 3 has no effect on any output.
- R7: `parity_warn_o` is 1 when byte 0 has even parity, or when byte 0 is 0x7F and byte 1 has even parity. The warning never changes `match_o`.
- R8: `match_o` is 1 when `mfr_id_o` equals `exp_mfr_i` and `dev_id_o` equals `exp_dev_i`.
- R9: `match_o` is 1 when `mfr_id_o` equals `exp_mfr_i` and `exp_dev_i` is the device wildcard (default 0xFFFF).
- R10: `match_o` is 1 when `exp_mfr_i` is the manufacturer wildcard (default 0xFFFE) and `mfr_id_o` is not 0x00FF. In every case not covered by R8 to R10, `match_o` is 0.
- R11: `done_o` is a single-cycle pulse. The result outputs are stable from that pulse until the next accepted start.
- R12: After reset `spi_cs_n_o` = 1, `spi_req_o` = 0, `busy_o` = 0, `done_o` = 0, `match_o` = 0, `parity_warn_o` = 0, and both ID outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| four_byte_i | input | 1 | 1 = read four response bytes, 0 = three |
| exp_mfr_i | input | 16 | Expected manufacturer code |
| exp_dev_i | input | 16 | Expected device code |
| spi_req_o | output | 1 | Byte transfer request to the shifter |
| spi_tx_o | output | 8 | Byte to send, valid while requesting |
| spi_ack_i | input | 1 | Shifter finished the byte this cycle |
| spi_rx_i | input | 8 | Byte received, valid with acknowledge |
| spi_cs_n_o | output | 1 | Flash chip select, active low |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle result pulse |
| mfr_id_o | output | 16 | Parsed manufacturer code |
| dev_id_o | output | 16 | Parsed device code |
| match_o | output | 1 | Identification matched |
| parity_warn_o | output | 1 | Parity warning on the manufacturer bytes |

## Verification
A byte counter that is off by one shows up at the ports within one transaction. The transfer count at the done pulse comes out wrong, and the parsed codes shift byte positions, so the very next vector misreports both IDs. A wrong state-machine exit shows as chip select high while a request is still pending, or as a second opcode, in the same cycle it happens. Wrong match or parity decoding is visible at the done pulse of the first vector that exercises the affected wildcard or continuation case.

// File: rtl/idp_pkg.sv
package idp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    localparam logic [7:0] ID_READ_OPCODE = 8'h9F;
    localparam logic [7:0] ID_FILL_BYTE   = 8'h00;
    localparam logic [7:0] ID_CONT_CODE   = 8'h7F;

endpackage

// File: rtl/idp_seq.sv
module idp_seq #(
    parameter int BYTE_W   = 8,
    parameter int MAX_RESP = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         four_byte_i,
    output logic                         spi_req_o,
    output logic [BYTE_W-1:0]            spi_tx_o,
    input  logic                         spi_ack_i,
    input  logic [BYTE_W-1:0]            spi_rx_i,
    output logic                         spi_cs_n_o,
    output logic                         busy_o,
    output logic                         fin_o,
    output logic                         four_o,
    output logic [MAX_RESP*BYTE_W-1:0]   resp_o
);
    import idp_pkg::*;

    localparam int CNT_W = $clog2(MAX_RESP + 1);

    typedef struct packed {
        seq_state_e                             state;
        logic [CNT_W-1:0]                       cnt;
        logic [CNT_W-1:0]                       last;
        logic                                   cs_n;
        logic                                   four;
        logic [MAX_RESP-1:0][BYTE_W-1:0]        bytes;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.state = ST_XFER;
                    seq_d.cnt   = '0;
                    seq_d.four  = four_byte_i;
                    seq_d.last  = four_byte_i ? CNT_W'(MAX_RESP) : CNT_W'(MAX_RESP - 1);
                    seq_d.cs_n  = 1'b0;
                    seq_d.bytes = '0;
                end
            end
            ST_XFER: begin
                if (spi_ack_i) begin
                    for (int k = 0; k < MAX_RESP; k++) begin
                        if (seq_q.cnt == CNT_W'(k + 1)) begin
                            seq_d.bytes[k] = spi_rx_i;
                        end
                    end
                    if (seq_q.cnt == seq_q.last) begin
                        seq_d.state = ST_FIN;
                        seq_d.cs_n  = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_FIN: begin
                seq_d.state = ST_IDLE;
            end
            default: begin
                seq_d.state = ST_IDLE;
                seq_d.cs_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= ST_IDLE;
            seq_q.cs_n  <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign spi_req_o  = (seq_q.state == ST_XFER);
    assign spi_tx_o   = (seq_q.cnt == '0) ? ID_READ_OPCODE : ID_FILL_BYTE;
    assign spi_cs_n_o = seq_q.cs_n;
    assign busy_o     = (seq_q.state != ST_IDLE);
    assign fin_o      = (seq_q.state == ST_FIN);
    assign four_o     = seq_q.four;
    assign resp_o     = seq_q.bytes;

endmodule

// File: rtl/idp_parse.sv
module idp_parse #(
    parameter int BYTE_W   = 8,
    parameter int MAX_RESP = 4,
    localparam int ID_W    = 2 * BYTE_W
) (
    input  logic [MAX_RESP*BYTE_W-1:0] resp_i,
    input  logic                       four_i,
    output logic [ID_W-1:0]            mfr_o,
    output logic [ID_W-1:0]            dev_o,
    output logic                       warn_o
);
    import idp_pkg::*;

    logic [BYTE_W-1:0] b [MAX_RESP];
    logic              cont;

    for (genvar g = 0; g < MAX_RESP; g++) begin : g_split
        assign b[g] = resp_i[g*BYTE_W +: BYTE_W];
    end

    assign cont = (b[0] == BYTE_W'(ID_CONT_CODE));

    always_comb begin
        if (cont) begin
            mfr_o = {b[0], b[1]};
            dev_o = four_i ? {b[2], b[3]} : {{BYTE_W{1'b0}}, b[2]};
        end else begin
            mfr_o = {{BYTE_W{1'b0}}, b[0]};
            dev_o = {b[1], b[2]};
        end
        warn_o = !(^b[0]) || (cont && !(^b[1]));
    end

endmodule

// File: rtl/idp_match.sv
module idp_match #(
    parameter int          ID_W     = 16,
    parameter logic [ID_W-1:0] WILD_MFR = 16'hFFFE,
    parameter logic [ID_W-1:0] WILD_DEV = 16'hFFFF,
    parameter logic [ID_W-1:0] NONE_MFR = 16'h00FF
) (
    input  logic [ID_W-1:0] mfr_i,
    input  logic [ID_W-1:0] dev_i,
    input  logic [ID_W-1:0] exp_mfr_i,
    input  logic [ID_W-1:0] exp_dev_i,
    output logic            match_o
);
    logic mfr_eq, dev_eq, dev_any, mfr_any;

    always_comb begin
        mfr_eq  = (mfr_i == exp_mfr_i);
        dev_eq  = (dev_i == exp_dev_i);
        dev_any = (exp_dev_i == WILD_DEV);
        mfr_any = (exp_mfr_i == WILD_MFR) && (mfr_i != NONE_MFR);
        match_o = (mfr_eq && (dev_eq || dev_any)) || mfr_any;
    end

endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe #(
    parameter int          BYTE_W   = 8,
    parameter int          MAX_RESP = 4,
    parameter logic [15:0] WILD_MFR = 16'hFFFE,
    parameter logic [15:0] WILD_DEV = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              four_byte_i,
    input  logic [15:0]       exp_mfr_i,
    input  logic [15:0]       exp_dev_i,
    output logic              spi_req_o,
    output logic [7:0]        spi_tx_o,
    input  logic              spi_ack_i,
    input  logic [7:0]        spi_rx_i,
    output logic              spi_cs_n_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [15:0]       mfr_id_o,
    output logic [15:0]       dev_id_o,
    output logic              match_o,
    output logic              parity_warn_o
);
    localparam int ID_W = 2 * BYTE_W;

    typedef struct packed {
        logic            done;
        logic [ID_W-1:0] mfr;
        logic [ID_W-1:0] dev;
        logic            match;
        logic            warn;
    } res_t;

    logic                         fin;
    logic                         four;
    logic [MAX_RESP*BYTE_W-1:0]   resp;
    logic [ID_W-1:0]              p_mfr, p_dev;
    logic                         p_warn, p_match;
    res_t                         res_d, res_q;

    idp_seq #(.BYTE_W(BYTE_W), .MAX_RESP(MAX_RESP)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .four_byte_i (four_byte_i),
        .spi_req_o   (spi_req_o),
        .spi_tx_o    (spi_tx_o),
        .spi_ack_i   (spi_ack_i),
        .spi_rx_i    (spi_rx_i),
        .spi_cs_n_o  (spi_cs_n_o),
        .busy_o      (busy_o),
        .fin_o       (fin),
        .four_o      (four),
        .resp_o      (resp)
    );

    idp_parse #(.BYTE_W(BYTE_W), .MAX_RESP(MAX_RESP)) u_parse (
        .resp_i (resp),
        .four_i (four),
        .mfr_o  (p_mfr),
        .dev_o  (p_dev),
        .warn_o (p_warn)
    );

    idp_match #(.ID_W(ID_W), .WILD_MFR(WILD_MFR), .WILD_DEV(WILD_DEV)) u_match (
        .mfr_i     (p_mfr),
        .dev_i     (p_dev),
        .exp_mfr_i (exp_mfr_i),
        .exp_dev_i (exp_dev_i),
        .match_o   (p_match)
    );

    always_comb begin
        res_d      = res_q;
        res_d.done = 1'b0;
        if (fin) begin
            res_d.done  = 1'b1;
            res_d.mfr   = p_mfr;
            res_d.dev   = p_dev;
            res_d.match = p_match;
            res_d.warn  = p_warn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign done_o        = res_q.done;
    assign mfr_id_o      = res_q.mfr;
    assign dev_id_o      = res_q.dev;
    assign match_o       = res_q.match;
    assign parity_warn_o = res_q.warn;

endmodule

// File: rtl/idp_chk.sv
module idp_chk #(
    parameter logic [15:0] WILD_MFR = 16'hFFFE
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        four_byte_i,
    input logic [15:0] exp_mfr_i,
    input logic        spi_req_o,
    input logic [7:0]  spi_tx_o,
    input logic        spi_ack_i,
    input logic        spi_cs_n_o,
    input logic        busy_o,
    input logic        done_o,
    input logic [15:0] mfr_id_o,
    input logic [15:0] dev_id_o,
    input logic        match_o,
    input logic        parity_warn_o
);
    logic [2:0] xfer_cnt;
    logic       four_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_cnt  <= '0;
            four_seen <= 1'b0;
        end else if (start_i && !busy_o) begin
            xfer_cnt  <= '0;
            four_seen <= four_byte_i;
        end else if (spi_req_o && spi_ack_i) begin
            xfer_cnt <= xfer_cnt + 3'd1;
        end
    end

    AST_OPCODE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n_o) |-> (spi_req_o && spi_tx_o == 8'h9F)); // R1

    AST_XFER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (xfer_cnt == (four_seen ? 3'd5 : 3'd4))); // R2

    AST_CS_DURING_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req_o |-> !spi_cs_n_o); // R3

    AST_CS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> spi_cs_n_o); // R3

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req_o && !spi_ack_i) |=> (spi_req_o && $stable(spi_tx_o))); // R2

    AST_NO_FALSE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && exp_mfr_i != WILD_MFR && mfr_id_o != exp_mfr_i) |-> !match_o); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(mfr_id_o) && $stable(dev_id_o)
                                   && $stable(match_o) && $stable(parity_warn_o))); // R11

endmodule

bind flash_id_probe idp_chk #(.WILD_MFR(WILD_MFR)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .four_byte_i   (four_byte_i),
    .exp_mfr_i     (exp_mfr_i),
    .spi_req_o     (spi_req_o),
    .spi_tx_o      (spi_tx_o),
    .spi_ack_i     (spi_ack_i),
    .spi_cs_n_o    (spi_cs_n_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .mfr_id_o      (mfr_id_o),
    .dev_id_o      (dev_id_o),
    .match_o       (match_o),
    .parity_warn_o (parity_warn_o)
);

// File: tb/flash_id_probe_tb.sv
module flash_id_probe_tb;

    localparam logic [15:0] WILD_M = 16'hFFFE;
    localparam logic [15:0] WILD_D = 16'hFFFF;
    localparam int NVEC = 12;

    // {four, b0, b1, b2, b3, exp_mfr, exp_dev}
    localparam logic [64:0] VEC [NVEC] = '{
        {1'b0, 8'hC2, 8'h20, 8'h18, 8'h00, 16'h00C2, 16'h2018},
        {1'b0, 8'hC2, 8'h20, 8'h18, 8'h00, 16'h00C2, 16'h2019},
        {1'b0, 8'hC2, 8'h20, 8'h19, 8'h00, 16'h00C2, 16'hFFFF},
        {1'b1, 8'h7F, 8'h9D, 8'h46, 8'h33, 16'h7F9D, 16'h4633},
        {1'b0, 8'h7F, 8'h9D, 8'h46, 8'h33, 16'h7F9D, 16'h0046},
        {1'b1, 8'hEF, 8'h40, 8'h17, 8'h55, 16'h00EF, 16'h4017},
        {1'b0, 8'hFF, 8'hFF, 8'hFF, 8'h00, 16'hFFFE, 16'h1234},
        {1'b0, 8'h20, 8'h20, 8'h15, 8'h00, 16'hFFFE, 16'h1234},
        {1'b0, 8'hC3, 8'h20, 8'h18, 8'h00, 16'h00C3, 16'h2018},
        {1'b0, 8'h7F, 8'h9C, 8'h46, 8'h00, 16'h7F9C, 16'h0046},
        {1'b1, 8'h7F, 8'h9D, 8'h46, 8'h33, 16'h7F9D, 16'hFFFF},
        {1'b0, 8'h1F, 8'h20, 8'h18, 8'h00, 16'h00C2, 16'h2018}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        four_byte_i = 1'b0;
    logic [15:0] exp_mfr_i = '0;
    logic [15:0] exp_dev_i = '0;
    logic        spi_req_o;
    logic [7:0]  spi_tx_o;
    logic        spi_ack_i = 1'b0;
    logic [7:0]  spi_rx_i = '0;
    logic        spi_cs_n_o;
    logic        busy_o;
    logic        done_o;
    logic [15:0] mfr_id_o;
    logic [15:0] dev_id_o;
    logic        match_o;
    logic        parity_warn_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    flash_id_probe u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .four_byte_i(four_byte_i),
        .exp_mfr_i(exp_mfr_i), .exp_dev_i(exp_dev_i),
        .spi_req_o(spi_req_o), .spi_tx_o(spi_tx_o), .spi_ack_i(spi_ack_i),
        .spi_rx_i(spi_rx_i), .spi_cs_n_o(spi_cs_n_o), .busy_o(busy_o),
        .done_o(done_o), .mfr_id_o(mfr_id_o), .dev_id_o(dev_id_o),
        .match_o(match_o), .parity_warn_o(parity_warn_o)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model(input logic four, input logic [7:0] b0, b1, b2, b3,
                         input logic [15:0] em, ed,
                         output logic [15:0] m, d, output logic mt, w);
        logic cont;
        cont = (b0 == 8'h7F);
        if (cont) begin
            m = {b0, b1};
            d = four ? {b2, b3} : {8'h00, b2};
        end else begin
            m = {8'h00, b0};
            d = {b1, b2};
        end
        w  = ((^b0) == 1'b0) || (cont && ((^b1) == 1'b0));
        mt = ((m == em) && (d == ed)) || ((m == em) && (ed == WILD_D))
             || ((em == WILD_M) && (m != 16'h00FF));
    endtask

    task automatic run_txn(input logic four, input logic [7:0] b0, b1, b2, b3,
                           input logic [15:0] em, ed, input logic poke);
        logic [7:0]  rsp [4];
        logic [15:0] xm, xd;
        logic        xmt, xw;
        int          n, waits;
        string       ptag, mtag;
        rsp[0] = b0; rsp[1] = b1; rsp[2] = b2; rsp[3] = b3;
        model(four, b0, b1, b2, b3, em, ed, xm, xd, xmt, xw);
        ptag = (b0 == 8'h7F) ? "R5" : (four ? "R6" : "R4");
        mtag = (em == WILD_M) ? "R10" : ((ed == WILD_D) ? "R9" : "R8");
        n = four ? 5 : 4;
        @(negedge clk);
        four_byte_i = four; exp_mfr_i = em; exp_dev_i = ed; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            waits = 0;
            while (!spi_req_o && waits < 20) begin
                @(negedge clk);
                waits++;
            end
            chk(spi_req_o, "R2", "request for byte", {31'd0, spi_req_o}, 1);
            chk(spi_tx_o == ((i == 0) ? 8'h9F : 8'h00), (i == 0) ? "R1" : "R2",
                "tx byte", {24'd0, spi_tx_o}, (i == 0) ? 32'h9F : 32'h00);
            chk(!spi_cs_n_o, "R3", "cs low during transfer", {31'd0, spi_cs_n_o}, 0);
            if (poke && i == 2) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            spi_ack_i = 1'b1;
            spi_rx_i  = (i == 0) ? 8'hA5 : rsp[i-1];
            @(negedge clk);
            spi_ack_i = 1'b0;
            spi_rx_i  = 8'h00;
        end
        waits = 0;
        while (!done_o && waits < 10) begin
            chk(!spi_req_o, "R2", "no extra byte", {31'd0, spi_req_o}, 0);
            @(negedge clk);
            waits++;
        end
        chk(done_o, "R11", "done pulse", {31'd0, done_o}, 1);
        chk(spi_cs_n_o, "R3", "cs high at done", {31'd0, spi_cs_n_o}, 1);
        chk(mfr_id_o == xm, ptag, "manufacturer", {16'd0, mfr_id_o}, {16'd0, xm});
        chk(dev_id_o == xd, ptag, "device", {16'd0, dev_id_o}, {16'd0, xd});
        chk(parity_warn_o == xw, "R7", "parity warning", {31'd0, parity_warn_o}, {31'd0, xw});
        chk(match_o == xmt, mtag, "match", {31'd0, match_o}, {31'd0, xmt});
        @(negedge clk);
        chk(!done_o, "R11", "done single cycle", {31'd0, done_o}, 0);
        repeat (3) @(negedge clk);
        chk(!spi_req_o && spi_cs_n_o && !busy_o, "R1", "idle after transaction",
            {29'd0, spi_req_o, spi_cs_n_o, busy_o}, 32'h2);
        chk(mfr_id_o == xm && dev_id_o == xd && match_o == xmt, "R11", "results held",
            {mfr_id_o, dev_id_o}, {xm, xd});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(spi_cs_n_o && !spi_req_o && !busy_o && !done_o && !match_o && !parity_warn_o,
            "R12", "reset controls",
            {26'd0, spi_cs_n_o, spi_req_o, busy_o, done_o, match_o, parity_warn_o}, 32'h20);
        chk(mfr_id_o == 16'h0 && dev_id_o == 16'h0, "R12", "reset ids",
            {mfr_id_o, dev_id_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            run_txn(VEC[v][64], VEC[v][63:56], VEC[v][55:48], VEC[v][47:40],
                    VEC[v][39:32], VEC[v][31:16], VEC[v][15:0], 1'b0);
        end

        // R6: fourth byte differs, outputs unchanged from vector 5
        run_txn(1'b1, 8'hEF, 8'h40, 8'h17, 8'hAA, 16'h00EF, 16'h4017, 1'b0);
        chk(dev_id_o == 16'h4017 && match_o, "R6", "byte 3 ignored",
            {15'd0, match_o, dev_id_o}, 32'h14017);

        // R1: start pulse while busy is ignored (run_txn checks idle after)
        run_txn(1'b1, 8'h7F, 8'h9D, 8'h46, 8'h33, 16'h7F9D, 16'h4633, 1'b1);
        run_txn(1'b0, 8'hC2, 8'h20, 8'h18, 8'h00, 16'h00C2, 16'h2018, 1'b1);

        // R10: wildcard manufacturer with continuation code matches
        run_txn(1'b0, 8'h7F, 8'h9D, 8'h20, 8'h00, 16'hFFFE, 16'h0000, 1'b0);
        chk(match_o, "R10", "wildcard with continuation", {31'd0, match_o}, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule